// File: doc/BRIEF.md
# Real-Time-Clock Prescaler with Coarse Trim

This block divides a slow reference clock down to a one-second strobe in two stages. A clock-enable input `ref_en` marks each reference-clock cycle within the fast system clock domain. A first divider counts `async_div + 1` reference cycles per first-stage tick (`apre_tick`). A second divider counts `sync_div + 1` first-stage ticks per second (`spre_tick`). All ticks are single-cycle pulses in the system clock domain.

Coarse trimming works on the first-stage tick stream. The block keeps a second-of-minute counter (`SECS_PER_MIN` seconds) and a minute-of-cycle counter (`MIN_PER_CYCLE` minutes). The cycle starts when init mode is left. In the first `2 × trim_mag` minutes of each cycle, the first second of the minute is changed. With `trim_neg = 0` (speed up), two extra first-stage ticks are inserted on the first two reference cycles of that second. With `trim_neg = 1` (slow down), the first natural first-stage tick of that second is dropped. All other seconds run at the nominal length. The divisors and the trim settings are captured only while `init_mode` is high. A first-stage divisor below `MIN_ADIV` is flagged on `cfg_invalid`, and trimming is then disabled. The block has no data stream, so all its pins are plain control and status signals with no valid/ready handshake.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: While `init_mode` is 1, neither `apre_tick` nor `spre_tick` pulses, and both dividers, the second counter and the minute counter are held at zero.
- R2: Without trimming, `apre_tick` pulses on every `(async_div+1)`-th `ref_en` cycle, and `spre_tick` pulses on every `(async_div+1)*(sync_div+1)`-th `ref_en` cycle, counted from the release of init mode.
- R3: With `trim_mag = 0`, the `spre_tick` timing is identical to the untrimmed timing of R2, for either value of `trim_neg`.
- R4: With `trim_neg = 0`, an affected second lasts `(sync_div-1)*(async_div+1)` `ref_en` cycles. Two inserted ticks appear on its first two `ref_en` cycles.
- R5: With `trim_neg = 1`, the first natural `apre_tick` of an affected second is suppressed, and the second lasts `(sync_div+2)*(async_div+1)` `ref_en` cycles.
- R6: Minutes are numbered 0 to `MIN_PER_CYCLE-1` from the release of init mode and wrap around after the last one. A minute is affected when its number is below `2*trim_mag`.
- R7: Only second 0 of an affected minute is changed. Every other second has the nominal length.
- R8: When the captured `async_div` is below `MIN_ADIV` (6), `cfg_invalid` is 1 and no trimming is applied. Otherwise `cfg_invalid` is 0.
- R9: Changes to `async_div`, `sync_div`, `trim_neg` or `trim_mag` while `init_mode` is 0 have no effect on the tick timing.
- R10: Each second contains exactly `sync_div+1` `apre_tick` pulses, with inserted ticks counted and suppressed ones not counted.
- R11: `apre_tick` and `spre_tick` pulse only in cycles where `ref_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_en | input | 1 | One-cycle enable per reference-clock cycle |
| init_mode | input | 1 | High: hold the counters and capture the settings |
| async_div | input | 7 | First-stage divisor minus one |
| sync_div | input | 15 | Second-stage divisor minus one |
| trim_neg | input | 1 | 0 = insert two ticks, 1 = drop one tick |
| trim_mag | input | 5 | Trim magnitude; affected minutes = 2 × value |
| apre_tick | output | 1 | First-stage tick after trimming |
| spre_tick | output | 1 | One-second tick |
| cfg_invalid | output | 1 | Captured first-stage divisor is too small for trimming |

## Verification
On every cycle, the assertions check the following: the quiet hold in init mode, that the captured settings do not change outside init mode, that the counters stay in range, and that the pending-correction budget fits the selected sign and is empty when the configuration is invalid. The bench's scenarios must show the following: the exact second lengths across a full 64-minute cycle and its wrap back to minute 0, the difference between the two trim signs, the count of first-stage ticks per second with a gapped `ref_en`, and that settings written outside init mode are ignored.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  localparam int ADIV_W  = 7;
  localparam int SDIV_W  = 15;
  localparam int MAG_W   = 5;
  localparam int MIN_ADIV = 6;

  typedef struct packed {
    logic [ADIV_W-1:0] adiv;
    logic [SDIV_W-1:0] sdiv;
    logic              neg;
    logic [MAG_W-1:0]  mag;
  } trim_cfg_t;

  // correction budget for one second: 0 none, 1 drop, 2 insert twice
  function automatic logic [1:0] corr_amount(input logic valid, input logic neg,
                                             input logic [MAG_W-1:0] mag,
                                             input logic first_sec,
                                             input int unsigned minute);
    if (valid && first_sec && (minute < 2 * int'(mag)))
      return neg ? 2'd1 : 2'd2;
    return 2'd0;
  endfunction
endpackage

// File: rtl/rtc_async_stage.sv
module rtc_async_stage #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  input  logic             neg,
  input  logic [1:0]       corr_left,
  output logic             apre_tick,
  output logic             corr_used
);
  logic [DIV_W-1:0] cnt_q;
  logic run, wrap, inject, mask;

  assign run    = ref_en && !hold;
  assign wrap   = (cnt_q == div);
  assign inject = run && !wrap && !neg && (corr_left != 2'd0);
  assign mask   = run && wrap && neg && (corr_left != 2'd0);
  assign apre_tick = (run && wrap && !mask) || inject;
  assign corr_used = inject || mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (hold)  cnt_q <= '0;
    else if (run)   cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  AST_ASYNC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (cnt_q <= $past(div))) else $error("async count out of range"); // R2
  AST_ASYNC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0)) else $error("async stage not held"); // R1
endmodule

// File: rtl/rtc_sync_stage.sv
module rtc_sync_stage #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             apre_tick,
  input  logic [DIV_W-1:0] div,
  output logic             spre_tick
);
  logic [DIV_W-1:0] cnt_q;

  assign spre_tick = apre_tick && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (hold)       cnt_q <= '0;
    else if (apre_tick)  cnt_q <= spre_tick ? '0 : cnt_q + 1'b1;
  end

  AST_SYNC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0)) else $error("sync stage not held"); // R1
endmodule

// File: rtl/rtc_trim_sequencer.sv
module rtc_trim_sequencer
  import rtc_trim_pkg::*;
#(
  parameter int SECS_PER_MIN  = 60,
  parameter int MIN_PER_CYCLE = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  logic       spre_tick,
  input  logic       corr_used,
  input  logic       valid,
  input  logic       neg,
  input  logic [MAG_W-1:0] mag,
  output logic [1:0] corr_left
);
  localparam int SEC_W = (SECS_PER_MIN  > 1) ? $clog2(SECS_PER_MIN)  : 1;
  localparam int MIN_W = (MIN_PER_CYCLE > 1) ? $clog2(MIN_PER_CYCLE) : 1;

  logic [SEC_W-1:0] sec_q, sec_nx;
  logic [MIN_W-1:0] min_q, min_nx;
  logic             last_sec;

  assign last_sec = (int'(sec_q) == SECS_PER_MIN - 1);
  assign sec_nx   = last_sec ? '0 : sec_q + 1'b1;
  assign min_nx   = !last_sec ? min_q :
                    (int'(min_q) == MIN_PER_CYCLE - 1) ? '0 : min_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0; min_q <= '0; corr_left <= 2'd0;
    end else if (hold) begin
      sec_q <= '0; min_q <= '0;
      corr_left <= corr_amount(valid, neg, mag, 1'b1, 0);
    end else if (spre_tick) begin
      sec_q <= sec_nx; min_q <= min_nx;
      corr_left <= corr_amount(valid, neg, mag, sec_nx == '0, int'(min_nx));
    end else if (corr_used && corr_left != 2'd0) begin
      corr_left <= corr_left - 2'd1;
    end
  end

  AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sec_q) < SECS_PER_MIN) else $error("second counter out of range"); // R7
  AST_MIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(min_q) < MIN_PER_CYCLE) else $error("minute counter out of range"); // R6
  AST_MINUTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (sec_q == '0 && min_q == '0)) else $error("minute counters not held"); // R1
  AST_NEG_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && neg) |-> corr_left <= 2'd1) else $error("drop budget above one"); // R5
  AST_INVALID_NO_CORR: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !valid) |-> corr_left == 2'd0) else $error("trim active while invalid"); // R8
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int SECS_PER_MIN  = 60,
  parameter int MIN_PER_CYCLE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic              init_mode,
  input  logic [ADIV_W-1:0] async_div,
  input  logic [SDIV_W-1:0] sync_div,
  input  logic              trim_neg,
  input  logic [MAG_W-1:0]  trim_mag,
  output logic              apre_tick,
  output logic              spre_tick,
  output logic              cfg_invalid
);
  trim_cfg_t cfg_q, cfg_in, cfg_eff;
  logic      valid, corr_used;
  logic [1:0] corr_left;

  assign cfg_in  = '{adiv: async_div, sdiv: sync_div, neg: trim_neg, mag: trim_mag};
  assign cfg_eff = init_mode ? cfg_in : cfg_q;
  assign valid   = (int'(cfg_eff.adiv) >= MIN_ADIV);
  assign cfg_invalid = !valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= '{adiv: 7'd127, sdiv: 15'd255, neg: 1'b0, mag: '0};
    else if (init_mode) cfg_q <= cfg_in;
  end

  rtc_async_stage #(.DIV_W(ADIV_W)) u_async (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .hold(init_mode),
    .div(cfg_eff.adiv), .neg(cfg_eff.neg), .corr_left(corr_left),
    .apre_tick(apre_tick), .corr_used(corr_used));

  rtc_sync_stage #(.DIV_W(SDIV_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .hold(init_mode), .apre_tick(apre_tick),
    .div(cfg_eff.sdiv), .spre_tick(spre_tick));

  rtc_trim_sequencer #(.SECS_PER_MIN(SECS_PER_MIN), .MIN_PER_CYCLE(MIN_PER_CYCLE)) u_seq (
    .clk(clk), .rst_n(rst_n), .hold(init_mode), .spre_tick(spre_tick),
    .corr_used(corr_used), .valid(valid), .neg(cfg_eff.neg), .mag(cfg_eff.mag),
    .corr_left(corr_left));

  AST_QUIET_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init_mode |-> (!apre_tick && !spre_tick)) else $error("tick during init"); // R1
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_mode && $past(!init_mode)) |-> $stable(cfg_q)) else $error("settings changed outside init"); // R9
  AST_SECOND_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    spre_tick |-> (apre_tick && ref_en)) else $error("second tick without stage tick"); // R11
endmodule

// File: tb/rtc_trim_prescaler_tb.sv
module rtc_trim_prescaler_tb;
  localparam int SECS = 4;
  localparam int MINS = 64;

  logic clk = 1'b0, rst_n = 1'b0, ref_en = 1'b0, init_mode = 1'b1;
  logic [6:0] async_div = 7'd6;
  logic [14:0] sync_div = 15'd3;
  logic trim_neg = 1'b0;
  logic [4:0] trim_mag = 5'd0;
  logic apre_tick, spre_tick, cfg_invalid;

  int checks = 0, errors = 0, cycles = 0;
  int m_a, m_s, m_dc, m_neg, m_valid;
  int c, n, next_exp, apre_cnt;
  string label;

  always #4 clk = ~clk;

  rtc_trim_prescaler #(.SECS_PER_MIN(SECS), .MIN_PER_CYCLE(MINS)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .init_mode(init_mode),
    .async_div(async_div), .sync_div(sync_div), .trim_neg(trim_neg),
    .trim_mag(trim_mag), .apre_tick(apre_tick), .spre_tick(spre_tick),
    .cfg_invalid(cfg_invalid));

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      if (errors < 20) $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 190000);
      finish_run();
    end
  end

  // reference second length in ref_en cycles
  function automatic int sec_len(input int k);
    int mn = (k / SECS) % MINS;
    bit aff = (m_valid != 0) && (k % SECS == 0) && (mn < 2 * m_dc);
    if (!aff) return m_s * m_a;
    return (m_neg != 0) ? (m_s + 1) * m_a : (m_s - 2) * m_a;
  endfunction

  task automatic step(input logic en, input logic ini);
    bit expv;
    @(negedge clk);
    ref_en = en; init_mode = ini;
    #2;
    if (ini) begin
      check(!apre_tick && !spre_tick, "R1 quiet in init", int'(apre_tick | spre_tick), 0);
      return;
    end
    check(en || (!apre_tick && !spre_tick), "R11 tick without ref_en", int'(apre_tick), 0);
    expv = 1'b0;
    if (en) begin
      c++;
      expv = (c == next_exp);
    end
    if (apre_tick) apre_cnt++;
    check(spre_tick == expv, {label, " second tick timing"}, int'(spre_tick), int'(expv));
    if (spre_tick) begin
      check(apre_cnt == m_s, "R10 stage ticks per second", apre_cnt, m_s);
      apre_cnt = 0;
    end
    if (expv) begin
      n++;
      next_exp += sec_len(n);
    end
  endtask

  task automatic run_case(input int adiv, input int sdiv, input int neg, input int dc,
                          input bit gap, input bit meddle, input int nsec, input string lbl);
    async_div = 7'(adiv); sync_div = 15'(sdiv); trim_neg = neg[0]; trim_mag = 5'(dc);
    m_a = adiv + 1; m_s = sdiv + 1; m_dc = dc; m_neg = neg; m_valid = (adiv >= 6);
    label = lbl;
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
    check(cfg_invalid == !m_valid, "R8 invalid flag", int'(cfg_invalid), int'(!m_valid));
    c = 0; n = 0; apre_cnt = 0; next_exp = sec_len(0);
    for (int i = 0; n < nsec && i < 40000; i++) begin
      step(gap ? logic'(i % 2) : 1'b1, 1'b0);
      if (meddle && i == 1) begin
        trim_mag = 5'd0; trim_neg = ~trim_neg; async_div = 7'd20; sync_div = 15'd9;
      end
    end
    check(n == nsec, {lbl, " seconds completed"}, n, nsec);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state in init: no ticks (R1)
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1);
    check(cfg_invalid == 1'b0, "R8 reset flag", int'(cfg_invalid), 0);
    // R2 R3: no trim, both signs
    run_case(6, 3, 0, 0, 1'b0, 1'b0, 70, "R2/R3 trim0 pos");
    run_case(8, 4, 1, 0, 1'b0, 1'b0, 70, "R3 trim0 neg");
    // R4 R6 R7: insert, full cycle plus wrap into minute 0
    run_case(6, 3, 0, 3, 1'b0, 1'b0, SECS * MINS + 6, "R4/R6/R7 insert");
    // R5 R6 R7: drop, full cycle plus wrap
    run_case(6, 3, 1, 3, 1'b0, 1'b0, SECS * MINS + 6, "R5/R6/R7 drop");
    // R6: maximum magnitude, last two minutes uncorrected
    run_case(6, 3, 0, 31, 1'b0, 1'b0, SECS * MINS + 6, "R6 max insert");
    // R11 R10: gapped ref_en with drop
    run_case(7, 4, 1, 2, 1'b1, 1'b0, 40, "R11/R5 gapped drop");
    // R9: settings changed after release are ignored
    run_case(6, 3, 0, 2, 1'b0, 1'b1, 40, "R9 ignore writes");
    // R8: divisor too small, trim disabled
    run_case(3, 3, 0, 5, 1'b0, 1'b0, 30, "R8 invalid no trim");
    // return to init: ticks stop again (R1)
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1);
    finish_run();
  end
endmodule